// File: doc/BRIEF.md
# Per-Channel Auxiliary Interrupt Aggregator

This block gathers event pulses from eight auxiliary-channel engines and turns them into one interrupt line for a host. Each channel reports four kinds of event: the plug pin went high, the plug pin went low, the attached sink asked for service, and a transaction finished. Every event kind on every channel has its own sticky pending flag and its own enable flag. The flags are packed four to a channel.

The host reaches the block over a small register bus with valid, write, address and data signals. It has two registers. The enable register at offset 0 reads back exactly what was written. To change single enables, the host reads the register, modifies the bits and writes it back. The status register at offset 4 reads back the pending flags gated by the enables. The host clears pending flags by writing ones to that register. The interrupt output is a registered OR over all enabled pending flags.

Top module: `aux_irq_agg`

## Requirements
- R1: After reset, the enable register, every pending flag and `irq` are zero. `bus_rdata` is also zero until the first read.
- R2: A write with address 0 loads the enable register. A read is a cycle with `bus_valid` high and `bus_write` low. It presents the addressed register on `bus_rdata` one clock after the read cycle and holds it there until the next read.
- R3: A one-cycle pulse of an event input for channel i sets pending bit 4*i+k. Here k is 0 for `ev_plug_hi`, 1 for `ev_plug_lo`, 2 for `ev_sink_req` and 3 for `ev_xfer_done`. No other bit changes.
- R4: A read of address 4 returns the pending flags ANDed with the enable register.
- R5: A write to address 4 clears each pending bit whose data bit is one. Pending bits whose data bit is zero keep their value.
- R6: If an event and a host clear hit the same pending bit in the same cycle, the bit ends up set. Other bits named by the same clear are still cleared.
- R7: `irq` equals the OR of all 32 enabled pending bits, delayed by one clock.
- R8: Writes to any address other than 0 and 4 change nothing. Reads from such addresses return zero.
- R9: Pending flags are captured whether or not they are enabled. A masked flag drives neither `irq` nor the status read. Once the host enables it, it shows up on both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| ev_plug_hi | input | 8 | Per-channel plug-high event pulse |
| ev_plug_lo | input | 8 | Per-channel plug-low event pulse |
| ev_sink_req | input | 8 | Per-channel sink request pulse |
| ev_xfer_done | input | 8 | Per-channel transaction done pulse |
| irq | output | 1 | Combined interrupt, registered |

## Verification
An event pulse from a channel engine and a host clear of the status register can land in the same clock cycle. The bench forces this case on purpose. In one bus cycle it raises a plug-high event on one channel and writes a clear mask. That mask names the bit being set and also a second bit that was set earlier. A following status read must show the colliding bit still set and the other bit cleared. This proves that the event wins only where it collides.

// File: rtl/aux_irq_pkg.sv
package aux_irq_pkg;
  localparam int unsigned EVT_PER_CH = 4;
  localparam int unsigned BUS_DW     = 32;

  // position of each event kind inside a channel nibble
  typedef enum logic [1:0] {
    EVK_PLUG_HI  = 2'd0,
    EVK_PLUG_LO  = 2'd1,
    EVK_SINK_REQ = 2'd2,
    EVK_XFER_END = 2'd3
  } evt_kind_e;

  localparam logic [3:0] OFS_ENABLE = 4'h0;
  localparam logic [3:0] OFS_STATUS = 4'h4;
endpackage

// File: rtl/aux_irq_rst_sync.sv
module aux_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/aux_irq_pending.sv
module aux_irq_pending #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] pend_q
);
  logic [WIDTH-1:0] pend_d;
  logic             pend_en;

  always_comb begin
    pend_en = (|set_i) | (|clr_i);
    // set takes priority over clear on a collision
    pend_d  = (pend_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  // R5
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/aux_irq_regbus.sv
module aux_irq_regbus
  import aux_irq_pkg::*;
#(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic [REG_W-1:0]  pend_q,
  output logic [REG_W-1:0]  en_q,
  output logic [REG_W-1:0]  clr_o,
  output logic [BUS_DW-1:0] bus_rdata
);
  logic              hit_en, hit_st;
  logic              en_we, rd_en;
  logic [REG_W-1:0]  en_d;
  logic [BUS_DW-1:0] rdata_d, rdata_q;

  always_comb begin
    hit_en  = (bus_addr == ADDR_W'(OFS_ENABLE));
    hit_st  = (bus_addr == ADDR_W'(OFS_STATUS));
    en_we   = bus_valid & bus_write & hit_en;
    en_d    = bus_wdata[REG_W-1:0];
    clr_o   = (bus_valid & bus_write & hit_st) ? bus_wdata[REG_W-1:0] : '0;
    rd_en   = bus_valid & ~bus_write;
    rdata_d = '0;
    if (hit_en)      rdata_d[REG_W-1:0] = en_q;
    else if (hit_st) rdata_d[REG_W-1:0] = pend_q & en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // R8
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write && bus_addr == ADDR_W'(OFS_ENABLE)) |=> $stable(en_q));

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata));
endmodule

// File: rtl/aux_irq_agg.sv
module aux_irq_agg
  import aux_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_CH-1:0] ev_plug_hi,
  input  logic [NUM_CH-1:0] ev_plug_lo,
  input  logic [NUM_CH-1:0] ev_sink_req,
  input  logic [NUM_CH-1:0] ev_xfer_done,
  output logic              irq
);
  localparam int unsigned REG_W = NUM_CH * EVT_PER_CH;

  logic             rst_n_sync;
  logic [REG_W-1:0] set_vec, clr_vec, pend_q, en_q;
  logic             irq_d, irq_q;

  aux_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign set_vec[ch*EVT_PER_CH + int'(EVK_PLUG_HI)]  = ev_plug_hi[ch];
    assign set_vec[ch*EVT_PER_CH + int'(EVK_PLUG_LO)]  = ev_plug_lo[ch];
    assign set_vec[ch*EVT_PER_CH + int'(EVK_SINK_REQ)] = ev_sink_req[ch];
    assign set_vec[ch*EVT_PER_CH + int'(EVK_XFER_END)] = ev_xfer_done[ch];
  end

  aux_irq_regbus #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend_q    (pend_q),
    .en_q      (en_q),
    .clr_o     (clr_vec),
    .bus_rdata (bus_rdata)
  );

  aux_irq_pending #(.WIDTH(REG_W)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .pend_q (pend_q)
  );

  always_comb irq_d = |(pend_q & en_q);

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    1'b1 |=> (irq == $past(|(pend_q & en_q))));

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (en_q == '0) |=> !irq);
endmodule

// File: tb/tb_aux_irq_agg.sv
module tb_aux_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  ev_hi = '0, ev_lo = '0, ev_sr = '0, ev_xd = '0;
  logic        irq;
  int          n_chk = 0, n_err = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  aux_irq_agg dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_plug_hi(ev_hi), .ev_plug_lo(ev_lo), .ev_sink_req(ev_sr),
    .ev_xfer_done(ev_xd), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_ev(input int ch, input int k, input logic v);
    case (k)
      0: ev_hi[ch] = v;
      1: ev_lo[ch] = v;
      2: ev_sr[ch] = v;
      default: ev_xd[ch] = v;
    endcase
  endtask

  task automatic pulse(input int ch, input int k);
    @(negedge clk);
    set_ev(ch, k, 1'b1);
    @(negedge clk);
    set_ev(ch, k, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] m;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    bus_rd(4'h0, rd); chk("R1 enable", rd, 32'h0);
    bus_wr(4'h0, 32'hFFFF_FFFF);
    bus_rd(4'h4, rd); chk("R1 pending", rd, 32'h0);
    bus_rd(4'h0, rd); chk("R2 enable all", rd, 32'hFFFF_FFFF);

    // R3/R5/R7 sweep every channel and kind
    for (int ch = 0; ch < 8; ch++) begin
      for (int k = 0; k < 4; k++) begin
        m = 32'h1 << (ch*4 + k);
        pulse(ch, k);
        @(negedge clk);
        chk("R7 irq rise", {31'b0, irq}, 32'h1);
        bus_rd(4'h4, rd); chk("R3 single bit", rd, m);
        bus_wr(4'h4, m);
        @(negedge clk);
        chk("R7 irq fall", {31'b0, irq}, 32'h0);
        bus_rd(4'h4, rd); chk("R5 cleared", rd, 32'h0);
      end
    end

    // R4 masking: all pending, various enables
    @(negedge clk);
    ev_hi = 8'hFF; ev_lo = 8'hFF; ev_sr = 8'hFF; ev_xd = 8'hFF;
    @(negedge clk);
    ev_hi = '0; ev_lo = '0; ev_sr = '0; ev_xd = '0;
    for (int k = 0; k < 4; k++) begin
      m = 32'h1111_1111 << k;
      bus_wr(4'h0, m);
      bus_rd(4'h0, rd); chk("R2 kind enable", rd, m);
      bus_rd(4'h4, rd); chk("R4 kind mask", rd, m);
    end
    for (int ch = 0; ch < 8; ch++) begin
      m = 32'hF << (ch*4);
      bus_wr(4'h0, m);
      bus_rd(4'h4, rd); chk("R4 channel mask", rd, m);
      chk("R7 irq masked on", {31'b0, irq}, 32'h1);
    end

    // R5 partial clear
    bus_wr(4'h0, 32'hFFFF_FFFF);
    bus_wr(4'h4, 32'hA5A5_0F0F);
    bus_rd(4'h4, rd); chk("R5 partial clear", rd, ~32'hA5A5_0F0F);
    bus_wr(4'h4, 32'hFFFF_FFFF);
    bus_rd(4'h4, rd); chk("R5 full clear", rd, 32'h0);

    // R6 collision: bit 12 set and cleared together, bit 4 cleared
    pulse(1, 0);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h0000_1010;
    ev_hi[3] = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; ev_hi[3] = 1'b0;
    bus_rd(4'h4, rd); chk("R6 event wins", rd, 32'h0000_1000);
    bus_wr(4'h4, 32'hFFFF_FFFF);

    // R9 masked capture
    bus_wr(4'h0, 32'h0);
    pulse(5, 2);
    @(negedge clk); @(negedge clk);
    chk("R9 irq masked", {31'b0, irq}, 32'h0);
    bus_rd(4'h4, rd); chk("R9 status masked", rd, 32'h0);
    bus_wr(4'h0, 32'h1 << 22);
    @(negedge clk);
    chk("R9 irq after enable", {31'b0, irq}, 32'h1);
    bus_rd(4'h4, rd); chk("R9 status after enable", rd, 32'h0040_0000);

    // R8 unmapped offsets
    bus_wr(4'h8, 32'hFFFF_FFFF);
    bus_wr(4'hC, 32'hFFFF_FFFF);
    bus_rd(4'h0, rd); chk("R8 enable untouched", rd, 32'h0040_0000);
    bus_rd(4'h4, rd); chk("R8 pending untouched", rd, 32'h0040_0000);
    bus_rd(4'h8, rd); chk("R8 read 8", rd, 32'h0);
    bus_rd(4'hC, rd); chk("R8 read C", rd, 32'h0);
    bus_rd(4'h2, rd); chk("R8 read 2", rd, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule